// File: doc/BRIEF.md
# Power Mode Clock Controller

This block sits between a small processor core and its oscillators. It decides which of three clock sources drives the core: the primary oscillator, a slow secondary oscillator, or the internal oscillator block. It also drives two separate clock enables, one for the core and one for the peripherals. Together these produce seven power modes:

- three run modes, where the core and the peripherals are both clocked;
- three idle modes, where only the peripherals are clocked;
- one sleep mode, where everything is stopped.

Software writes a control register that holds an idle-enable bit and a 2-bit source select. A one-cycle strobe from the core's sleep instruction moves the block out of run. The idle-enable bit then decides whether it enters idle or full sleep. A wake event brings it back to run.

A source switch takes effect at once when the target oscillator reports that it is running. Otherwise the block stays on the current source and shows a pending flag until the target is ready. All gating is done with enables. The oscillators and any analog clock multiplexing belong elsewhere.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: The source select maps to the active-source index as follows: 00 gives index 0 (primary), 01 gives index 1 (secondary), and both 10 and 11 give index 2 (internal). Bit i of `osc_ready` is the running flag of source index i.
- R2: In a run mode, `cpu_clk_en` and `per_clk_en` are both 1.
- R3: In an idle mode, `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R4: In sleep, both enables are 0 and `mode` is 000. The active source is held and `switch_pending` is 0, whatever is written to the source select or reported on `osc_ready`.
- R5: A `sleep_req` pulse in a run mode takes effect at that clock edge. If the stored idle-enable bit is 1, the block enters the idle mode of the active source; if it is 0, the block enters sleep. An idle-enable value written in the same cycle as the pulse is not used for that decision.
- R6: In a run or idle mode, a write whose target source is running changes `act_src` at the same clock edge as the write. The same holds at the edge of a wake from sleep.
- R7: When the target source is not running, `act_src` keeps the previous source and `switch_pending` is 1. The switch completes, and the flag clears, at the first edge where the target's running flag is 1. Selecting the current active source again also clears the flag.
- R8: `wake_evt` in idle or sleep returns the block to the run mode at the next edge, with both enables set to 1. In a run mode, `wake_evt` has no effect.
- R9: `sleep_req` has no effect in idle or sleep. When `sleep_req` and `wake_evt` arrive together in idle or sleep, the wake wins.
- R10: After reset the block is in primary run: `mode` is 001, `act_src` is 0, both enables are 1 and `switch_pending` is 0. The stored idle-enable bit is 0, so a following `sleep_req` enters sleep.
- R11: `mode` encoding:
  - 000 is sleep;
  - 001, 010 and 011 are run on the primary, secondary and internal source;
  - 101, 110 and 111 are idle on the same three sources;
  - 100 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_idle_en | input | 1 | Idle-enable value to write |
| ctl_src_sel | input | 2 | Source select value to write |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| osc_ready | input | 3 | Per-source running flags, bit i for source index i |
| wake_evt | input | 1 | Wake event |
| act_src | output | 2 | Index of the source currently in use |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode | output | 3 | Current power mode code |
| switch_pending | output | 1 | A requested source is not yet running |

## Verification
The bench builds the block with its default of three sources, a 2-bit select and a 3-bit mode code. With these values, every select code (including both internal aliases) and all seven modes can be reached within a few hundred cycles.

Random `osc_ready` patterns often hold back the target source. Together with random writes, this exercises pending switches that complete or are retargeted. Random sleep and wake strobes cover the run, idle and sleep transitions, including strobes that collide with writes and with each other.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int NUM_SRC = 3;
  localparam int SRC_W   = 2;
  localparam int SEL_W   = 2;
  localparam int MODE_W  = 3;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_IDLE  = 2'd1,
    PS_SLEEP = 2'd2
  } pstate_e;

  localparam logic [SRC_W-1:0] SRC_PRI = SRC_W'(0);
  localparam logic [SRC_W-1:0] SRC_SEC = SRC_W'(1);
  localparam logic [SRC_W-1:0] SRC_INT = SRC_W'(2);

  // select bit 1 set picks the internal block regardless of bit 0
  function automatic logic [SRC_W-1:0] sel_to_src(input logic [SEL_W-1:0] sel);
    if (sel[1]) return SRC_INT;
    if (sel[0]) return SRC_SEC;
    return SRC_PRI;
  endfunction

  // top bit flags idle, low bits carry source index plus one, all zero is sleep
  function automatic logic [MODE_W-1:0] mode_code(input pstate_e st,
                                                  input logic [SRC_W-1:0] src);
    logic [MODE_W-1:0] m;
    if (st == PS_SLEEP) begin
      m = '0;
    end else begin
      m = MODE_W'(src) + MODE_W'(1);
      m[MODE_W-1] = (st == PS_IDLE);
    end
    return m;
  endfunction
endpackage

// File: rtl/pcc_ctl_reg.sv
module pcc_ctl_reg
  import pcc_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int IW = SRC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_idle,
  input  logic [SW-1:0] wr_sel,
  output logic          idle_q,
  output logic [SW-1:0] sel_q,
  output logic [IW-1:0] tgt_src
);
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= 1'b0;
      sel_q  <= '0;
    end else if (wr_en) begin
      idle_q <= wr_idle;
      sel_q  <= wr_sel;
    end
  end

  // a write in flight is visible to the source tracker in its own cycle
  always_comb begin
    tgt_src = wr_en ? sel_to_src(wr_sel) : sel_to_src(sel_q);
  end

  AST_TGT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    tgt_src != IW'(3)) else $error("target index out of range"); // R1
endmodule

// File: rtl/pcc_mode_fsm.sv
module pcc_mode_fsm
  import pcc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sleep_req,
  input  logic    wake,
  input  logic    idle_q,
  output pstate_e st_q,
  output pstate_e st_nx
);
  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      PS_RUN:           if (sleep_req) st_nx = idle_q ? PS_IDLE : PS_SLEEP;
      PS_IDLE, PS_SLEEP: if (wake)     st_nx = PS_RUN;
      default:                         st_nx = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PS_RUN;
    else     st_q <= st_nx;
  end

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_RUN && sleep_req && idle_q) |=> st_q == PS_IDLE)
    else $error("idle entry missed"); // R5
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_RUN && sleep_req && !idle_q) |=> st_q == PS_SLEEP)
    else $error("sleep entry missed"); // R5
  AST_WAKE_RUN: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_RUN && wake) |=> st_q == PS_RUN)
    else $error("wake did not return to run"); // R8
  AST_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_RUN && !wake) |=> $stable(st_q))
    else $error("low-power state left without wake"); // R9
  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (rst)
    st_q inside {PS_RUN, PS_IDLE, PS_SLEEP})
    else $error("illegal state"); // R11
endmodule

// File: rtl/pcc_src_track.sv
module pcc_src_track
  import pcc_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int IW = SRC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] tgt_src,
  input  logic [NS-1:0] osc_ready,
  input  logic          freeze,
  output logic [IW-1:0] act_q,
  output logic [IW-1:0] act_nx,
  output logic          pend_q
);
  localparam int PAD = 2 ** IW;

  logic [PAD-1:0] rdy_pad;
  logic [PAD-1:0] rdy_prev;
  logic           pend_nx;

  for (genvar g = 0; g < PAD; g++) begin : g_rdy
    if (g < NS) begin : g_real
      assign rdy_pad[g] = osc_ready[g];
    end else begin : g_pad
      assign rdy_pad[g] = 1'b0;
    end
  end

  always_comb begin
    act_nx  = act_q;
    pend_nx = 1'b0;
    if (!freeze) begin
      if (rdy_pad[tgt_src]) act_nx = tgt_src;
      else                  pend_nx = (tgt_src != act_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= SRC_PRI;
      pend_q <= 1'b0;
    end else begin
      act_q  <= act_nx;
      pend_q <= pend_nx;
    end
  end

  always_ff @(posedge clk) rdy_prev <= rdy_pad;

  AST_SWITCH_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> rdy_prev[act_q])
    else $error("switched to a stopped source"); // R7
  AST_FROZEN_IN_SLEEP: assert property (@(posedge clk) disable iff (rst)
    freeze |=> (!pend_q && $stable(act_q)))
    else $error("source moved during sleep"); // R4
endmodule

// File: rtl/pcc_out_stage.sv
module pcc_out_stage
  import pcc_pkg::*;
#(
  parameter int IW = SRC_W,
  parameter int MW = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  pstate_e       st_nx,
  input  logic [IW-1:0] act_nx,
  output logic          cpu_en,
  output logic          per_en,
  output logic [MW-1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_en <= 1'b1;
      per_en <= 1'b1;
      mode   <= mode_code(PS_RUN, SRC_PRI);
    end else begin
      cpu_en <= (st_nx == PS_RUN);
      per_en <= (st_nx != PS_SLEEP);
      mode   <= mode_code(st_nx, act_nx);
    end
  end

  AST_MODE_NO_GAP: assert property (@(posedge clk) disable iff (rst)
    mode != MW'(4)) else $error("unused mode code"); // R11
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              ctl_idle_en,
  input  logic [SEL_W-1:0]  ctl_src_sel,
  input  logic              sleep_req,
  input  logic [NUM_SRC-1:0] osc_ready,
  input  logic              wake_evt,
  output logic [SRC_W-1:0]  act_src,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic [MODE_W-1:0] mode,
  output logic              switch_pending
);
  logic             idle_q;
  logic [SEL_W-1:0] sel_q;
  logic [SRC_W-1:0] tgt_src;
  logic [SRC_W-1:0] act_nx;
  pstate_e          st_q;
  pstate_e          st_nx;

  pcc_ctl_reg #(.SW(SEL_W), .IW(SRC_W)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(ctl_we), .wr_idle(ctl_idle_en),
    .wr_sel(ctl_src_sel), .idle_q(idle_q), .sel_q(sel_q), .tgt_src(tgt_src)
  );

  pcc_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake(wake_evt),
    .idle_q(idle_q), .st_q(st_q), .st_nx(st_nx)
  );

  pcc_src_track #(.NS(NUM_SRC), .IW(SRC_W)) u_src (
    .clk(clk), .rst(rst), .tgt_src(tgt_src), .osc_ready(osc_ready),
    .freeze(st_nx == PS_SLEEP), .act_q(act_src), .act_nx(act_nx),
    .pend_q(switch_pending)
  );

  pcc_out_stage #(.IW(SRC_W), .MW(MODE_W)) u_out (
    .clk(clk), .rst(rst), .st_nx(st_nx), .act_nx(act_nx),
    .cpu_en(cpu_clk_en), .per_en(per_clk_en), .mode(mode)
  );

  AST_SLEEP_DARK: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_SLEEP) |-> (!cpu_clk_en && !per_clk_en && mode == '0))
    else $error("clock enabled in sleep"); // R4
  AST_IDLE_PER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_IDLE) |-> (!cpu_clk_en && per_clk_en))
    else $error("idle enables wrong"); // R3
  AST_RUN_BOTH: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_RUN) |-> (cpu_clk_en && per_clk_en))
    else $error("run enables wrong"); // R2
  AST_PEND_ONLY_AWAKE: assert property (@(posedge clk) disable iff (rst)
    switch_pending |-> per_clk_en)
    else $error("pending while asleep"); // R7
  AST_SEL_STORED: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> sel_q == $past(ctl_src_sel))
    else $error("select write lost"); // R1
endmodule

// File: tb/tb_pwr_clk_ctrl.sv
module tb_pwr_clk_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       ctl_we, ctl_idle_en, sleep_req, wake_evt;
  logic [1:0] ctl_src_sel;
  logic [2:0] osc_ready;
  logic [1:0] act_src;
  logic       cpu_clk_en, per_clk_en, switch_pending;
  logic [2:0] mode;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model: state 0 run, 1 idle, 2 sleep
  int     m_st, m_act;
  bit     m_idle, m_pend;
  bit [1:0] m_sel;

  always #10 clk = ~clk;

  pwr_clk_ctrl dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_idle_en(ctl_idle_en),
    .ctl_src_sel(ctl_src_sel), .sleep_req(sleep_req), .osc_ready(osc_ready),
    .wake_evt(wake_evt), .act_src(act_src), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .mode(mode), .switch_pending(switch_pending)
  );

  function automatic int sel_src(bit [1:0] s);
    return s[1] ? 2 : (s[0] ? 1 : 0);
  endfunction

  function automatic bit [2:0] exp_mode(int st, int src);
    if (st == 2) return 3'b000;
    return {st == 1, 2'(src + 1)};
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "mode", int'(mode), int'(exp_mode(m_st, m_act)));
    chk(tag, "cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0));
    chk(tag, "per_clk_en", int'(per_clk_en), int'(m_st != 2));
    chk(tag, "act_src", int'(act_src), m_act);
    chk(tag, "switch_pending", int'(switch_pending), int'(m_pend));
  endtask

  task automatic step(bit we, bit idl, bit [1:0] sel, bit slp, bit wk,
                      bit [2:0] rdy, string tag);
    int tgt, ns;
    ctl_we = we; ctl_idle_en = idl; ctl_src_sel = sel;
    sleep_req = slp; wake_evt = wk; osc_ready = rdy;
    @(posedge clk);
    tgt = we ? sel_src(sel) : sel_src(m_sel);
    if (m_st == 0) ns = slp ? (m_idle ? 1 : 2) : 0;
    else           ns = wk ? 0 : m_st;
    if (we) begin m_idle = idl; m_sel = sel; end
    if (ns == 2)         m_pend = 1'b0;
    else if (rdy[tgt]) begin m_act = tgt; m_pend = 1'b0; end
    else                 m_pend = (tgt != m_act);
    m_st = ns;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    rst = 1'b1; ctl_we = 0; ctl_idle_en = 0; ctl_src_sel = 0;
    sleep_req = 0; wake_evt = 0; osc_ready = 3'b111;
    m_st = 0; m_act = 0; m_idle = 0; m_pend = 0; m_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    compare("R10 reset");

    // strobe with a same-cycle idle write: stored bit 0 still picks sleep
    step(1, 1, 2'b00, 1, 0, 3'b111, "R5 R10");
    step(1, 1, 2'b01, 1, 0, 3'b111, "R4 R9");
    step(0, 0, 2'b00, 0, 1, 3'b111, "R8 R6");
    step(0, 0, 2'b00, 1, 0, 3'b111, "R5 R3");
    step(0, 0, 2'b00, 1, 0, 3'b111, "R9");
    step(1, 1, 2'b11, 0, 0, 3'b111, "R6 R1");
    step(0, 0, 2'b00, 1, 1, 3'b111, "R9 R8");
    step(1, 1, 2'b10, 0, 0, 3'b111, "R1");
    step(1, 1, 2'b00, 0, 0, 3'b110, "R7");
    step(0, 0, 2'b00, 0, 0, 3'b110, "R7");
    step(0, 0, 2'b00, 0, 0, 3'b111, "R7");
    step(1, 1, 2'b01, 0, 0, 3'b101, "R7");
    step(1, 1, 2'b00, 0, 0, 3'b101, "R7");
    step(0, 0, 2'b00, 0, 1, 3'b111, "R8 R2");
    step(1, 0, 2'b00, 1, 0, 3'b111, "R5");
    step(0, 0, 2'b00, 0, 1, 3'b111, "R8");
    step(0, 0, 2'b00, 1, 0, 3'b111, "R5 R4");
    step(1, 1, 2'b11, 0, 0, 3'b000, "R4");
    step(0, 0, 2'b00, 0, 1, 3'b111, "R8 R11 R6");

    for (int i = 0; i < 800; i++) begin
      bit [2:0] r;
      r = ($urandom % 3 == 0) ? 3'($urandom % 8) : 3'b111;
      step(($urandom % 4) == 0, 1'($urandom % 2), 2'($urandom % 4),
           ($urandom % 5) == 0, ($urandom % 4) == 0, r, "random R11");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule